// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit, 8-input successive-approximation analog-to-digital converter. A single-cycle start request, accepted only while the block is idle, captures the requested input number and the conversion-clock divide setting. The block then opens a fixed sampling window on the selected input. After that it runs a binary search in which it drives a trial code to an external DAC and reads the one-bit answer of an external comparator. When the fixed conversion budget has run out, it stores the 8-bit code and raises a completion flag.

All conversion timing counts ticks of a conversion clock. That clock is an enable pulse made by dividing the system clock by 2, 4, 8 or 16. A conversion always spans the same number of ticks: sampling, then one decision per bit, most significant bit first, and then idle ticks that fill out the budget. Software-visible timing therefore depends only on the divide setting, never on the input voltage.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `dac_code` and `sample_en` are all zero.
- R2: A start pulse while `busy` is low is accepted at that clock edge. From the next cycle on, `busy` is 1, `done` is 0 and `ch_mux` equals the `chan_sel` value given with the start, and `ch_mux` holds that value until `busy` falls.
- R3: `sample_en` is high for exactly the first 12 conversion ticks of each conversion, which is 12×D system cycles starting with the first cycle `busy` is high, where D is the divide value.
- R4: The divide value D is fixed at start. With `adc_alt`=0: `clk_sel` 00 gives 2, 01 gives 4, and 10 or 11 give 16. With `adc_alt`=1: `clk_sel` 00 gives 2, and any other value gives 8.
- R5: `busy` stays high for exactly 160×D system cycles per conversion.
- R6: The search tests bits from bit 7 down to bit 0. Each trial adds the bit under test to the code kept so far, and the bit is kept only if `comp_in` is 1, which means the input is at or above the trial level. For an ideal comparator the result therefore equals the largest code not above the input.
- R7: Zero transition: an input level of 0 gives code 00h, and a level of 1 gives 01h.
- R8: Full-scale transition: an input level of 254 gives FEh, and a level of 255 gives FFh.
- R9: A start pulse while `busy` is high is ignored. The channel, the divide value and the conversion length are unchanged, and `done` stays low.
- R10: `result` updates and `done` rises at the same edge at which `busy` falls. Both hold until the next accepted start, which clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, one cycle |
| chan_sel | input | 3 | Input channel for the next conversion |
| adc_alt | input | 1 | Converter divide-mode bit (R4) |
| clk_sel | input | 2 | Clock-select bits (R4) |
| comp_in | input | 1 | Comparator answer: 1 when input ≥ `dac_code` |
| ch_mux | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample-and-hold window |
| dac_code | output | 8 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Completion flag |
| result | output | 8 | Last conversion code |

## Verification
The search is tried with input levels at the two ends of the range (0, 1, 254, 255), at the two codes on either side of mid-scale (7Fh, 80h), and at alternating-bit codes (55h, AAh). The edge values separate a wrong comparison sense or an off-by-one threshold. The mid-scale pair and the alternating pair show whether each bit decision is kept or dropped on its own, in MSB-first order. Every divide setting is run so that the busy length and the sampling length tell the divide values apart. One conversion is disturbed by a second start carrying a different channel and divide setting, to show that the captured settings survive it.

// File: rtl/sar_pkg.sv
// Package: shared constants and the divide-select decode for the conversion
// sequencer. Assumes every divide value is a power of two between 2 and MAX_DIV.
package sar_pkg;
    localparam int MAX_DIV = 16;
    localparam int DIV_W   = $clog2(MAX_DIV) + 1;

    // Decode the divide-mode bit and the clock-select bits into a divide value.
    function automatic logic [DIV_W-1:0] div_of(input logic alt, input logic [1:0] sel);
        logic [DIV_W-1:0] d;
        if (sel == 2'b00)   d = DIV_W'(2);
        else if (alt)       d = DIV_W'(8);
        else if (sel == 2'b01) d = DIV_W'(4);
        else                d = DIV_W'(16);
        return d;
    endfunction
endpackage

// File: rtl/sar_prescaler.sv
// Prescaler: emits a one-cycle conversion tick every DIV system cycles while
// running. Restarts its phase on an accepted start so that the tick timing
// is exact. Assumes div is 2 or more and is held stable while run is high.
module sar_prescaler
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W - 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_W'(div - DIV_W'(1)));

    // Count system cycles within one conversion-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (tick)         cnt_q <= '0;
        else if (run)          cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_div_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div == DIV_W'(2) || div == DIV_W'(4) || div == DIV_W'(8) || div == DIV_W'(16)));
endmodule

// File: rtl/sar_timeline.sv
// Timeline: counts conversion ticks and decodes them into the sampling
// window, the bit-trial windows (BIT_TICKS ticks per bit, MSB first), the
// decision strobe and the final tick. Assumes the budget holds all phases.
module sar_timeline #(
    parameter int RES_BITS     = 8,
    parameter int SAMPLE_TICKS = 12,
    parameter int BIT_TICKS    = 2,
    parameter int TOTAL_TICKS  = 160,
    localparam int PH_W        = $clog2(TOTAL_TICKS),
    localparam int BI_W        = $clog2(RES_BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            busy,
    input  logic            tick,
    output logic            sample_en,
    output logic            bit_active,
    output logic [BI_W-1:0] bit_idx,
    output logic            decide,
    output logic            last
);
    localparam logic [PH_W-1:0] SAMP_END = PH_W'(SAMPLE_TICKS);
    localparam logic [PH_W-1:0] BITS_END = PH_W'(SAMPLE_TICKS + RES_BITS * BIT_TICKS);
    localparam logic [PH_W-1:0] BT       = PH_W'(BIT_TICKS);
    localparam logic [PH_W-1:0] RMAX     = PH_W'(RES_BITS - 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(TOTAL_TICKS - 1);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] offs;
    logic            in_bits;

    // Advance the tick position once per conversion tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  phase_q <= '0;
        else if (busy && tick)  phase_q <= phase_q + PH_W'(1);
    end

    // Decode the tick position into phase windows and strobes.
    always_comb begin
        offs       = phase_q - SAMP_END;
        in_bits    = (phase_q >= SAMP_END) && (phase_q < BITS_END);
        sample_en  = busy && (phase_q < SAMP_END);
        bit_active = busy && in_bits;
        bit_idx    = BI_W'(RMAX - offs / BT);
        decide     = busy && tick && in_bits && ((offs % BT) == BT - PH_W'(1));
        last       = busy && tick && (phase_q == PH_LAST);
    end

    assert_sample_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> busy);
    assert_decide_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> !sample_en);
endmodule

// File: rtl/sar_search.sv
// Search register: holds the code decided so far and forms the trial code
// by adding the bit under test. On a decision the bit is kept only when the
// comparator reports the input at or above the trial level.
module sar_search #(
    parameter int RES_BITS = 8,
    localparam int BI_W    = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                bit_active,
    input  logic [BI_W-1:0]     bit_idx,
    input  logic                decide,
    input  logic                comp_in,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] code_nxt
);
    logic [RES_BITS-1:0] sar_q;
    logic [RES_BITS-1:0] mask;

    // Form the trial code and the next kept code.
    always_comb begin
        mask     = RES_BITS'(1) << bit_idx;
        trial    = bit_active ? (sar_q | mask) : sar_q;
        code_nxt = (decide && comp_in) ? trial : sar_q;
    end

    // Hold the decided bits between trials.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sar_q <= '0;
        else                 sar_q <= code_nxt;
    end

    assert_kept_bits_from_trial_R6: assert property (@(posedge clk) disable iff (!rst_n || clear)
        decide |=> ((sar_q & ~$past(trial)) == '0));
endmodule

// File: rtl/sar_adc_seq.sv
// Top: accepts a start while idle, captures channel and divide setting,
// runs the fixed-length conversion through prescaler, timeline and search,
// and publishes the code with a completion flag. Starts while busy are dropped.
module sar_adc_seq
    import sar_pkg::*;
#(
    parameter int RES_BITS     = 8,
    parameter int N_CH         = 8,
    parameter int SAMPLE_TICKS = 12,
    parameter int BIT_TICKS    = 2,
    parameter int TOTAL_TICKS  = 160,
    localparam int CH_W        = $clog2(N_CH),
    localparam int BI_W        = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CH_W-1:0]     chan_sel,
    input  logic                adc_alt,
    input  logic [1:0]          clk_sel,
    input  logic                comp_in,
    output logic [CH_W-1:0]     ch_mux,
    output logic                sample_en,
    output logic [RES_BITS-1:0] dac_code,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result
);
    logic             accept;
    logic             tick;
    logic             bit_active;
    logic             decide;
    logic             last;
    logic [BI_W-1:0]  bit_idx;
    logic [DIV_W-1:0] div_q;
    logic [RES_BITS-1:0] code_nxt;

    assign accept = start && !busy;

    // Conversion control: capture settings, track busy, publish the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            ch_mux <= '0;
            div_q  <= DIV_W'(2);
            result <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            ch_mux <= chan_sel;
            div_q  <= div_of(adc_alt, clk_sel);
        end else if (last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= code_nxt;
        end
    end

    sar_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .div     (div_q),
        .tick    (tick)
    );

    sar_timeline #(
        .RES_BITS     (RES_BITS),
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .BIT_TICKS    (BIT_TICKS),
        .TOTAL_TICKS  (TOTAL_TICKS)
    ) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .busy       (busy),
        .tick       (tick),
        .sample_en  (sample_en),
        .bit_active (bit_active),
        .bit_idx    (bit_idx),
        .decide     (decide),
        .last       (last)
    );

    sar_search #(
        .RES_BITS (RES_BITS)
    ) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .bit_active (bit_active),
        .bit_idx    (bit_idx),
        .decide     (decide),
        .comp_in    (comp_in),
        .trial      (dac_code),
        .code_nxt   (code_nxt)
    );

    assert_chan_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch_mux));
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !done);
    assert_done_with_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(result));
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/tb_sar_adc_seq.sv
// Scoreboard bench: the driver pushes the expected code, channel and cycle
// counts; a monitor pops and compares them when busy falls.
module tb_sar_adc_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan_sel = '0;
    logic       adc_alt = 1'b0;
    logic [1:0] clk_sel = '0;
    logic       comp_in;
    logic [2:0] ch_mux;
    logic       sample_en;
    logic [7:0] dac_code;
    logic       busy;
    logic       done;
    logic [7:0] result;

    logic [7:0] vin [8];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int q_res[$];
    int q_ch[$];
    int q_len[$];
    int q_samp[$];

    always #10 clk = ~clk;

    // Ideal comparator: input at or above the trial level answers 1.
    assign comp_in = (vin[ch_mux] >= dac_code);

    sar_adc_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .adc_alt(adc_alt), .clk_sel(clk_sel), .comp_in(comp_in),
        .ch_mux(ch_mux), .sample_en(sample_en), .dac_code(dac_code),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int divide(input logic alt, input logic [1:0] sel);
        if (sel == 2'b00) return 2;
        if (alt) return 8;
        if (sel == 2'b01) return 4;
        return 16;
    endfunction

    // Monitor: measure each conversion and compare it with the scoreboard.
    int  len = 0;
    int  samp = 0;
    bit  prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                len++;
                if (sample_en) samp++;
                if (q_ch.size() != 0 && ch_mux != 3'(q_ch[0]))
                    chk(0, "R2 channel held", ch_mux, q_ch[0]);
            end
            if (prev_busy && !busy && q_res.size() != 0) begin
                chk(result == 8'(q_res[0]), "R6 result code", result, q_res[0]);
                chk(len == q_len[0], "R5 busy length", len, q_len[0]);
                chk(samp == q_samp[0], "R3 sample length", samp, q_samp[0]);
                chk(done == 1'b1, "R10 done with end", done, 1);
                void'(q_res.pop_front()); void'(q_ch.pop_front());
                void'(q_len.pop_front()); void'(q_samp.pop_front());
            end
            if (!busy) begin len = 0; samp = 0; end
            prev_busy = busy;
        end
    end

    // Driver: start one conversion, check acceptance, push expectations.
    task automatic convert(input int ch, input logic alt, input logic [1:0] sel,
                           input int level, input bit intrude);
        int d = divide(alt, sel);
        vin[ch] = 8'(level);
        q_res.push_back(level); q_ch.push_back(ch);
        q_len.push_back(160 * d); q_samp.push_back(12 * d);
        @(negedge clk);
        chan_sel = 3'(ch); adc_alt = alt; clk_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(done == 1'b0, "R2 done cleared", done, 0);
        chk(ch_mux == 3'(ch), "R2 channel captured", ch_mux, ch);
        if (intrude) begin
            repeat (40) @(negedge clk);
            chan_sel = 3'(ch + 3); adc_alt = ~alt; clk_sel = ~sel; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 busy kept", busy, 1);
            chk(done == 1'b0, "R9 done stays low", done, 0);
            chk(ch_mux == 3'(ch), "R9 channel kept", ch_mux, ch);
        end
        while (q_res.size() != 0) @(negedge clk);
        repeat (15) @(negedge clk);
        chk(done == 1'b1, "R10 done held", done, 1);
        chk(result == 8'(level), "R10 result held", result, level);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) vin[i] = '0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);
        chk(result == 8'h00, "R1 result reset", result, 0);
        chk(dac_code == 8'h00, "R1 dac reset", dac_code, 0);
        chk(sample_en == 1'b0, "R1 sample reset", sample_en, 0);
        rst_n = 1'b1;
        // R7 zero transition and R8 full-scale transition
        convert(0, 1'b0, 2'b00, 0, 0);
        convert(1, 1'b0, 2'b01, 1, 0);
        convert(2, 1'b0, 2'b10, 254, 0);
        convert(3, 1'b0, 2'b11, 255, 0);
        // R6 mid-scale and alternating patterns, R4 remaining divide settings
        convert(4, 1'b1, 2'b00, 8'h7F, 0);
        convert(5, 1'b1, 2'b01, 8'h80, 0);
        convert(6, 1'b1, 2'b10, 8'h55, 0);
        convert(7, 1'b1, 2'b11, 8'hAA, 0);
        // R9 start during a conversion with different settings
        convert(2, 1'b0, 2'b01, 8'h3C, 1);
        convert(6, 1'b1, 2'b00, 8'hC3, 1);
        chk(q_res.size() == 0, "R10 scoreboard drained", q_res.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(0, "R5 watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule